// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Capture

This block turns inbound message-signalled interrupt writes into latched per-vector status. A write from the far end of the link appears on a simple write port as a valid strobe with a 32-bit address and 32-bit data. The block accepts the write only when the address equals a configured match address. The low five bits of the data select one of 32 vectors, and that vector's status bit is set.

Local software reads the status through a small word-indexed register port. It clears bits by writing ones to a clear register and gates the single combined interrupt output with a global enable. A write to a vector that is still pending carries no new information. It is discarded rather than accumulated, and a counter records each discard. The block has no notion of port role, so it behaves identically whether the port is configured as root or as endpoint.

Local register word indices: 0 = status (read-only), 1 = clear (write-1-to-clear, reads as zero), 2 = control (bit 0 is the global enable, read/write), 3 = discard counter (read-only, zero-extended).

Top module: `msi_capture_top`

## Requirements
- R1: A link write with `linkWrValid` high and `linkWrAddr` equal to `MATCH_ADDR` sets status bit `linkWrData[4:0]` at the next clock edge and leaves the other status bits unchanged.
- R2: A link write whose address differs from `MATCH_ADDR`, or whose valid is low, changes neither status nor the discard counter.
- R3: Data bits [31:5] of a link write have no effect on which vector is set.
- R4: A matching link write to a vector whose status bit is already set leaves status unchanged and increments the discard counter (word 3) by one, unless that bit is cleared in the same cycle.
- R5: A register write to word 1 clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged. Reading word 1 returns zero.
- R6: When a matching link write and a clear hit the same bit in the same cycle, the bit ends set and the discard counter does not change.
- R7: `irqOut` is high exactly when the enable (word 2, bit 0) is 1 and at least one status bit is set. Status is captured whether or not the enable is set.
- R8: After reset, status, enable, discard counter and `irqOut` are all zero.
- R9: `regRdData` reflects the word selected by `regRdAddr` in the same cycle, without a clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkWrValid | input | 1 | Inbound link write strobe |
| linkWrAddr | input | 32 | Inbound write address |
| linkWrData | input | 32 | Inbound write data; bits [4:0] pick the vector |
| regWrEn | input | 1 | Local register write strobe |
| regWrAddr | input | 2 | Local register word index for writes |
| regWrData | input | 32 | Local register write data |
| regRdAddr | input | 2 | Local register word index for reads |
| regRdData | output | 32 | Read data for the selected word |
| irqOut | output | 1 | Combined interrupt, gated by the enable |

## Verification
The assertions check several relations on every cycle:
- an accepted write lands in its bit;
- no status bit rises without a set strobe;
- a pending bit survives until a clear reaches it;
- a clear without a competing set always takes effect;
- the discard counter only holds or steps by one;
- a set-versus-clear collision never counts a discard.

Some behaviour only the bench scenarios can show:
- that the vector comes from exactly the low data bits;
- that a mismatched address is ignored;
- the register map contents and the zero read of the clear word;
- the gating of the output by the enable.

For these, a behavioural model in the bench is compared against the ports on every clock.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int NUM_VEC   = 32;
  localparam int VEC_IDX_W = $clog2(NUM_VEC);
  localparam int REG_AW    = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_STATUS = 2'd0,
    REG_CLEAR  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_DROPS  = 2'd3
  } regWord_e;

  typedef struct packed {
    logic                 capValid;
    logic [VEC_IDX_W-1:0] capIdx;
    logic [NUM_VEC-1:0]   clrMask;
    logic                 ctrlWr;
    logic                 ctrlEn;
  } capStrobe_t;
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] MATCH_ADDR = 32'hFEE0_1000
) (
  input  logic              linkWrValid,
  input  logic [31:0]       linkWrAddr,
  input  logic [DATA_W-1:0] linkWrData,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  output capStrobe_t        strobe
);
  logic addrHit;
  logic unusedUpperData;
  logic [DATA_W-1:0] clrWide;

  assign addrHit = (linkWrAddr == MATCH_ADDR);
  // only the low index bits select a vector; the rest are discarded
  assign unusedUpperData = ^linkWrData[DATA_W-1:VEC_IDX_W];

  assign clrWide = (regWrEn && (regWrAddr == REG_CLEAR)) ? regWrData : '0;

  always_comb begin
    strobe          = '0;
    strobe.capValid = linkWrValid && addrHit;
    strobe.capIdx   = linkWrData[VEC_IDX_W-1:0];
    strobe.clrMask  = clrWide[NUM_VEC-1:0];
    strobe.ctrlWr   = regWrEn && (regWrAddr == REG_CTRL);
    strobe.ctrlEn   = regWrData[0];
  end
endmodule

// File: rtl/msi_cap_dpath.sv
module msi_cap_dpath
  import msi_cap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [NUM_VEC-1:0] statusQ;
  logic [NUM_VEC-1:0] setMask;
  logic [DROP_W-1:0]  dropQ;
  logic               enQ;
  logic               dropHit;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_setDecode
    assign setMask[v] = strobe.capValid && (strobe.capIdx == VEC_IDX_W'(v));
  end

  assign dropHit = strobe.capValid && statusQ[strobe.capIdx] &&
                   !strobe.clrMask[strobe.capIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      dropQ   <= '0;
      enQ     <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~strobe.clrMask) | setMask;
      if (dropHit) dropQ <= dropQ + 1'b1;
      if (strobe.ctrlWr) enQ <= strobe.ctrlEn;
    end
  end

  assign irqOut = enQ && (|statusQ);

  always_comb begin
    regRdData = '0;
    unique case (regRdAddr)
      REG_STATUS: regRdData[NUM_VEC-1:0] = statusQ;
      REG_CLEAR:  regRdData = '0;
      REG_CTRL:   regRdData[0] = enQ;
      REG_DROPS:  regRdData[DROP_W-1:0] = dropQ;
      default:    regRdData = '0;
    endcase
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capValid |=> statusQ[$past(strobe.capIdx)]); // R1
  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~$past(statusQ) & ~$past(setMask)) == '0); // R2
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusQ) & ~$past(strobe.clrMask) & ~statusQ) == '0); // R4
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dropQ == $past(dropQ)) || (dropQ == DROP_W'($past(dropQ) + 1'b1))); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.clrMask & ~setMask)) |=> ((statusQ & $past(strobe.clrMask & ~setMask)) == '0)); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.clrMask & setMask)) |=> (dropQ == $past(dropQ))); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |-> !irqOut); // R7
endmodule

// File: rtl/msi_capture_top.sv
module msi_capture_top
  import msi_cap_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          DROP_W     = 16,
  parameter logic [31:0] MATCH_ADDR = 32'hFEE0_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkWrValid,
  input  logic [31:0]       linkWrAddr,
  input  logic [DATA_W-1:0] linkWrData,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  capStrobe_t strobe;

  msi_cap_ctrl #(.DATA_W(DATA_W), .MATCH_ADDR(MATCH_ADDR)) ctrl_i (
    .linkWrValid(linkWrValid),
    .linkWrAddr (linkWrAddr),
    .linkWrData (linkWrData),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .strobe     (strobe)
  );

  msi_cap_dpath #(.DATA_W(DATA_W), .DROP_W(DROP_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regRdAddr(regRdAddr),
    .regRdData(regRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/msi_capture_top_tb_top.sv
`timescale 1ns/1ps
module msi_capture_top_tb_top;
  localparam logic [31:0] MADDR = 32'hFEE0_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkWrValid = 1'b0;
  logic [31:0] linkWrAddr = '0;
  logic [31:0] linkWrData = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R8";

  bit [31:0] mStat;
  bit        mEn;
  int unsigned mDrop;

  always #2.5 clk = ~clk;

  msi_capture_top #(.MATCH_ADDR(MADDR)) dut_i (
    .clk(clk), .rstN(rstN),
    .linkWrValid(linkWrValid), .linkWrAddr(linkWrAddr), .linkWrData(linkWrData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic bit [31:0] expRead(input bit [1:0] a);
    case (a)
      2'd0: return mStat;
      2'd2: return {31'b0, mEn};
      2'd3: return mDrop & 32'h0000_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(curReq, "irqOut", {31'b0, irqOut}, {31'b0, mEn && (mStat != 0)});
    check(curReq, "regRdData", regRdData, expRead(regRdAddr));
  endtask

  // behavioural reference update from the inputs held across the edge
  task automatic modelStep();
    bit [31:0] clr;
    bit [31:0] setm;
    int idx;
    if (!rstN) begin
      mStat = '0; mEn = 0; mDrop = 0;
      return;
    end
    clr  = (regWrEn && regWrAddr == 2'd1) ? regWrData : 32'h0;
    setm = 32'h0;
    idx  = int'(linkWrData[4:0]);
    if (linkWrValid && linkWrAddr == MADDR) begin
      setm[idx] = 1'b1;
      if (mStat[idx] && !clr[idx]) mDrop = (mDrop + 1) & 32'hFFFF;
    end
    mStat = (mStat & ~clr) | setm;
    if (regWrEn && regWrAddr == 2'd2) mEn = regWrData[0];
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleInputs();
    linkWrValid = 0; linkWrAddr = '0; linkWrData = '0;
    regWrEn = 0; regWrAddr = '0; regWrData = '0;
  endtask

  task automatic linkWr(input logic [31:0] a, input logic [31:0] d);
    linkWrValid = 1; linkWrAddr = a; linkWrData = d;
    tick();
    idleInputs();
  endtask

  task automatic regWr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1; regWrAddr = a; regWrData = d;
    tick();
    idleInputs();
  endtask

  task automatic both(input logic [31:0] d, input logic [31:0] clr);
    linkWrValid = 1; linkWrAddr = MADDR; linkWrData = d;
    regWrEn = 1; regWrAddr = 2'd1; regWrData = clr;
    tick();
    idleInputs();
  endtask

  task automatic peek(input string req, input logic [1:0] a, input logic [31:0] exp);
    regRdAddr = a;
    #0.5;
    check(req, "read", regRdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    idleInputs();
    repeat (3) tick();
    rstN = 1;
    // R8: reset state
    curReq = "R8";
    @(negedge clk);
    peek("R8", 2'd0, 32'h0);
    peek("R8", 2'd2, 32'h0);
    peek("R8", 2'd3, 32'h0);
    check("R8", "irqOut", {31'b0, irqOut}, 32'h0);
    regRdAddr = 2'd0;

    // R7: capture while disabled, no interrupt
    curReq = "R7";
    linkWr(MADDR, 32'd3);
    check("R7", "irq while disabled", {31'b0, irqOut}, 32'h0);
    peek("R7", 2'd0, 32'h0000_0008);
    regWr(2'd2, 32'h1);
    check("R7", "irq enabled", {31'b0, irqOut}, 32'h1);

    // R1: several vectors including edges
    curReq = "R1";
    linkWr(MADDR, 32'd31);
    linkWr(MADDR, 32'd0);
    peek("R1", 2'd0, 32'h8000_0009);

    // R2: mismatched address and invalid strobe
    curReq = "R2";
    linkWr(MADDR ^ 32'h4, 32'd12);
    linkWrValid = 0; linkWrAddr = MADDR; linkWrData = 32'd13;
    tick();
    idleInputs();
    peek("R2", 2'd0, 32'h8000_0009);
    peek("R2", 2'd3, 32'h0);

    // R3: upper data bits ignored
    curReq = "R3";
    linkWr(MADDR, 32'hABCD_EF07);
    peek("R3", 2'd0, 32'h8000_0089);

    // R4: repeat to pending vector dropped and counted
    curReq = "R4";
    linkWr(MADDR, 32'd3);
    linkWr(MADDR, 32'hFFFF_FFE3);
    peek("R4", 2'd0, 32'h8000_0089);
    peek("R4", 2'd3, 32'h2);

    // R5: write-1-to-clear, clear word reads zero
    curReq = "R5";
    regWr(2'd1, 32'h0000_0009);
    peek("R5", 2'd0, 32'h8000_0080);
    peek("R5", 2'd1, 32'h0);

    // R6: set and clear collide on pending bit 7 and idle bit 9
    curReq = "R6";
    both(32'd7, 32'h0000_0080);
    peek("R6", 2'd0, 32'h8000_0080);
    peek("R6", 2'd3, 32'h2);
    both(32'd9, 32'h0000_0200);
    peek("R6", 2'd0, 32'h8000_0280);

    // R7: disable with pending bits, then clear all with enable on
    curReq = "R7";
    regWr(2'd2, 32'h0);
    check("R7", "irq gated off", {31'b0, irqOut}, 32'h0);
    regWr(2'd2, 32'h1);
    regWr(2'd1, 32'hFFFF_FFFF);
    check("R7", "irq after clear-all", {31'b0, irqOut}, 32'h0);

    // R9: combinational read of each word without a clock
    curReq = "R9";
    linkWr(MADDR, 32'd17);
    peek("R9", 2'd0, 32'h0002_0000);
    peek("R9", 2'd2, 32'h1);
    peek("R9", 2'd3, 32'h2);

    // mixed traffic, model compared every clock
    curReq = "R1";
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      linkWrValid = lfsr[0];
      linkWrAddr  = lfsr[1] ? MADDR : (MADDR + 32'h10);
      linkWrData  = {lfsr[31:8], 3'b0, lfsr[6:2]};
      regWrEn     = lfsr[9] & lfsr[10];
      regWrAddr   = lfsr[12:11];
      regWrData   = {lfsr[15:0], lfsr[31:16]} & {32{lfsr[13]}} | {31'b0, lfsr[14]};
      regRdAddr   = lfsr[17:16];
      tick();
    end
    idleInputs();
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule